// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This block sits between a clocked host and an external asynchronous static RAM of 1M words of 32 bits. The host presents one request at a time: a read or a write, a 20-bit word address, write data, and four active-low byte-lane enables. The controller turns each request into a strobe sequence on the memory pins: chip select, write enable, output enable and four byte-lane selects, all active low. It holds each strobe for a number of clock cycles set by parameters, so that the access time, the write-pulse width, the address-to-end-of-write time and the output turn-off time of the memory's speed grade are met.

The data bus is split into an output word, a per-lane output enable for the pad drivers, and an input word, so the tristate pads can sit outside this block. On a read the controller samples the bus while chip select and output enable are still low, then releases the strobes. Lanes that were not selected read as zero. On a write only the selected lanes are driven, and the data is held for a recovery interval after write enable rises. Each request finishes with a one-cycle `done`, and `rvalid` goes with it for reads.

The defaults suit a 12 ns memory on a 100 MHz clock: two cycles of output enable for a read, one cycle of write pulse, and one recovery cycle after either operation.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset chip select, write enable, output enable and all four lane selects are high (inactive), no lane is driven, and `done` and `rvalid` are low.
- R2: A read accepted from idle puts the request address on `mem_addr`, drives chip select and output enable low with write enable high and lane selects equal to `be_n`, and keeps output enable low for exactly RD_CYC cycles. `rdata` is the bus value sampled on the last of those edges.
- R3: In a read, a lane whose `be_n` bit is 1 returns zero in `rdata`. A lane whose bit is 0 returns the memory content of that lane.
- R4: A write accepted from idle drives chip select and write enable low with output enable high. It holds write enable low for exactly WP_CYC cycles, drives exactly the lanes whose `be_n` bit is 0, and leaves the other lanes of the memory word unchanged.
- R5: After write enable rises, the write data stays driven on the same lanes for exactly REC_CYC cycles with all strobes high. After that no lane is driven.
- R6: No lane is ever driven while output enable is low, and output enable has been high for at least one full cycle before any lane starts to be driven.
- R7: `done` is a one-cycle pulse, RD_CYC+REC_CYC cycles after the accepting edge for a read and WP_CYC+REC_CYC cycles after it for a write. `rvalid` is high with `done` only for reads, and `rdata` keeps its value until the next read completes.
- R8: `req` is ignored while an operation is in progress: it starts no memory access and changes no stored data.
- R9: Whenever chip select is high, write enable and output enable are high and all lane selects are high. Write enable and output enable are never low together, and `mem_addr` does not change while chip select stays low.
- R10: Lane i (be_n bit i and lane select bit i) covers data bits 8i+7 down to 8i, on both the host words and the memory bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken only when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Word address |
| wdata | input | 32 | Write data |
| be_n | input | 4 | Active-low byte-lane enables |
| rdata | output | 32 | Read data, zero in unselected lanes |
| rvalid | output | 1 | Read data valid, with done |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 20 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_bs_n | output | 4 | Memory byte-lane selects, active low |
| mem_dq_o | output | 32 | Data to the bus pads |
| mem_dq_oe | output | 4 | Per-lane pad drive enable |
| mem_dq_i | input | 32 | Data from the bus pads |

## Verification
On every cycle the assertions check the pin-level rules: no drive while output enable is low, a quiet output-enable cycle before drive starts, write and output enable never low together, strobes released together with chip select, a stable address under chip select, driven lanes equal to selected lanes during the write pulse, and minimum widths for the read and write pulses. Only the bench's scenarios can show that data really moves. They sweep every lane pattern over sixteen addresses against a memory model that returns wrong data during the first cycle of output enable. This shows that reads sample late enough, that unselected lanes read as zero, that partial writes merge correctly, that completion latency is exact, and that a request made while busy leaves the memory untouched.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW      = 20,
  parameter int DW      = 32,
  parameter int LW      = 8,
  parameter int LANES   = DW / LW,
  parameter int RD_CYC  = 2,
  parameter int WP_CYC  = 1,
  parameter int REC_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             done,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [LANES-1:0] mem_bs_n,
  output logic [DW-1:0]    mem_dq_o,
  output logic [LANES-1:0] mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_i
);

  localparam int MAXC = (RD_CYC > WP_CYC) ? ((RD_CYC > REC_CYC) ? RD_CYC : REC_CYC)
                                          : ((WP_CYC > REC_CYC) ? WP_CYC : REC_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_REC} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          was_rd;

  wire rd_last  = (cnt == CW'(RD_CYC - 1));
  wire wr_last  = (cnt == CW'(WP_CYC - 1));
  wire rec_last = (cnt == CW'(REC_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      was_rd    <= 1'b0;
      rdata     <= '0;
      rvalid    <= 1'b0;
      done      <= 1'b0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_bs_n  <= '1;
      mem_dq_o  <= '0;
      mem_dq_oe <= '0;
    end else begin
      done   <= 1'b0;
      rvalid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            cnt      <= '0;
            mem_addr <= addr;
            mem_bs_n <= be_n;
            mem_ce_n <= 1'b0;
            was_rd   <= !we;
            if (we) begin
              mem_we_n  <= 1'b0;
              mem_dq_o  <= wdata;
              mem_dq_oe <= ~be_n;
              st        <= S_WRITE;
            end else begin
              mem_oe_n <= 1'b0;
              st       <= S_READ;
            end
          end
        end
        S_READ: begin
          if (rd_last) begin
            for (int i = 0; i < LANES; i++)
              rdata[i*LW +: LW] <= mem_bs_n[i] ? '0 : mem_dq_i[i*LW +: LW];
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_bs_n <= '1;
            cnt      <= '0;
            st       <= S_REC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WRITE: begin
          if (wr_last) begin
            mem_we_n <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_bs_n <= '1;
            cnt      <= '0;
            st       <= S_REC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (rec_last) begin
            mem_dq_oe <= '0;
            done      <= 1'b1;
            rvalid    <= was_rd;
            cnt       <= '0;
            st        <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

module sram_lane_ctrl_chk #(
  parameter int AW     = 20,
  parameter int LANES  = 4,
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             rvalid,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_ce_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic [LANES-1:0] mem_bs_n,
  input logic [LANES-1:0] mem_dq_oe
);

  logic [15:0] oe_run, we_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_run <= '0;
      we_run <= '0;
    end else begin
      oe_run <= mem_oe_n ? '0 : oe_run + 1'b1;
      we_run <= mem_we_n ? '0 : we_run + 1'b1;
    end
  end

  assert_no_drive_under_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != '0) |-> mem_oe_n);

  assert_oe_quiet_before_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_dq_oe != '0) && ($past(mem_dq_oe) == '0)) |-> $past(mem_oe_n));

  assert_strobes_idle_with_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && (mem_bs_n == '1)));

  assert_we_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_write_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe == ~mem_bs_n));

  assert_write_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= 16'(WP_CYC)));

  assert_read_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run >= 16'(RD_CYC)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rvalid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> done);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW(AW), .LANES(LANES), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .rvalid(rvalid), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_bs_n(mem_bs_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int RD = 2, WP = 1, RC = 1;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be_n = '1;
  logic [31:0] rdata, mem_dq_o, mem_dq_i;
  logic        rvalid, done, mem_ce_n, mem_we_n, mem_oe_n;
  logic [19:0] mem_addr;
  logic [3:0]  mem_bs_n, mem_dq_oe;

  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.RD_CYC(RD), .WP_CYC(WP), .REC_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .be_n(be_n), .rdata(rdata), .rvalid(rvalid), .done(done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_bs_n(mem_bs_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model: 16 words, data valid only from the second cycle of output enable
  logic [31:0] mem [16];
  int olc = 0;
  always @(posedge clk) olc <= (!mem_ce_n && !mem_oe_n) ? olc + 1 : 0;
  always_comb
    for (int i = 0; i < 4; i++)
      if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_bs_n[i])
        mem_dq_i[i*8 +: 8] = (olc >= 1) ? mem[mem_addr[3:0]][i*8 +: 8] : 8'hA5;
      else
        mem_dq_i[i*8 +: 8] = 8'hC3;
  always @(negedge clk)
    if (!mem_ce_n && !mem_we_n)
      for (int i = 0; i < 4; i++)
        if (!mem_bs_n[i] && mem_dq_oe[i]) mem[mem_addr[3:0]][i*8 +: 8] <= mem_dq_o[i*8 +: 8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pin monitor
  logic [19:0] cur_addr = '0;
  logic [3:0]  cur_be = '1;
  logic [3:0]  prev_oe = '0;
  logic        prev_oe_n = 1;
  int wl = 0, ol = 0, hc = 0;
  always @(negedge clk) if (rst_n) begin
    if (mem_dq_oe != 0 && !mem_oe_n) chk(0, "R6 drive with oe low", {28'd0, mem_dq_oe}, 0);
    if (mem_dq_oe != 0 && prev_oe == 0) chk(prev_oe_n, "R6 oe high before drive", {31'd0, prev_oe_n}, 1);
    if (!mem_ce_n) chk(mem_addr == cur_addr, "R2 address", {12'd0, mem_addr}, {12'd0, cur_addr});
    if (!mem_we_n) begin
      chk(mem_dq_oe == ~cur_be && mem_bs_n == cur_be && mem_oe_n, "R4 write lanes R10",
          {24'd0, mem_dq_oe, mem_bs_n}, {24'd0, ~cur_be, cur_be});
      wl++;
    end else if (wl != 0) begin
      chk(wl == WP, "R4 write pulse width", wl, WP);
      wl = 0;
    end
    if (!mem_oe_n) begin
      chk(mem_bs_n == cur_be && mem_we_n, "R2 read strobes", {27'd0, mem_we_n, mem_bs_n}, {27'd1, cur_be});
      ol++;
    end else if (ol != 0) begin
      chk(ol == RD, "R2 read pulse width", ol, RD);
      ol = 0;
    end
    if (mem_we_n && mem_dq_oe != 0) begin
      chk(mem_ce_n && mem_bs_n == 4'hF, "R5 hold with strobes high", {28'd0, mem_bs_n}, 32'hF);
      hc++;
    end else if (mem_dq_oe == 0 && hc != 0) begin
      chk(hc == RC, "R5 hold length", hc, RC);
      hc = 0;
    end
    prev_oe   = mem_dq_oe;
    prev_oe_n = mem_oe_n;
  end

  function automatic logic [19:0] fa(input int i);
    return {16'(16'h0B00 + i), 4'(i)};
  endfunction
  function automatic logic [31:0] pat(input int i);
    return (32'h01020304 * 32'(i + 1)) ^ 32'hA5A55A5A;
  endfunction
  function automatic logic [31:0] lmask(input logic [3:0] b);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = b[i] ? 8'h00 : 8'hFF;
    return m;
  endfunction

  logic [31:0] exp_mem [16];
  logic [31:0] last_rd = '0;

  task automatic op(input logic w, input int idx, input logic [31:0] wd,
                    input logic [3:0] be, input bit busy_req);
    int lat, want;
    want = w ? (WP + RC) : (RD + RC);
    @(negedge clk);
    req = 1; we = w; addr = fa(idx); wdata = wd; be_n = be;
    cur_addr = fa(idx); cur_be = be;
    @(negedge clk);
    if (busy_req) begin
      we = 1; addr = fa(idx ^ 1); wdata = ~wd; be_n = 4'h0;
    end else req = 0;
    lat = 0;
    while (!done && lat < 50) begin
      if (lat == want - 1) req = 0;
      @(negedge clk);
      lat++;
    end
    req = 0;
    chk(lat == want, "R7 done latency", lat, want);
    chk(rvalid == !w, "R7 rvalid with done", {31'd0, rvalid}, {31'd0, !w});
    if (w) begin
      exp_mem[idx] = (exp_mem[idx] & lmask(~be)) | (wd & lmask(be));
      chk(rdata == last_rd, "R7 rdata held over write", rdata, last_rd);
    end else begin
      chk(rdata == (exp_mem[idx] & lmask(be)), "R2 R3 R10 read data", rdata, exp_mem[idx] & lmask(be));
      last_rd = rdata;
    end
    @(negedge clk);
    chk(!done && !rvalid, "R7 done single pulse", {30'd0, done, rvalid}, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_bs_n == 4'hF, "R1 reset strobes",
        {25'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_bs_n}, 32'h7F);
    chk(mem_dq_oe == 0 && !done && !rvalid, "R1 reset outputs", {26'd0, mem_dq_oe, done, rvalid}, 0);
    rst_n = 1;
    for (int i = 0; i < 16; i++) op(1, i, pat(i), 4'h0, 0);
    for (int i = 0; i < 16; i++)
      for (int b = 0; b < 16; b++) op(0, i, 0, 4'(b), 0);
    for (int b = 0; b < 16; b++) begin
      op(1, b, ~pat(b) ^ 32'h1111_1111, 4'(b), 0);
      op(0, b, 0, 4'h0, 0);
    end
    op(0, 3, 0, 4'h0, 0);
    op(1, 5, 32'hDEAD_BEEF, 4'h0, 0);
    op(1, 6, 32'h0BAD_F00D, 4'h6, 1);
    op(0, 7, 0, 4'h0, 0);
    chk(mem[7] == exp_mem[7], "R8 busy request ignored", mem[7], exp_mem[7]);
    op(0, 6, 0, 4'h0, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R7 watchdog: done not seen, actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule